// File: doc/BRIEF.md
# Table-Mapped Gated Clock Divider

This block derives a slower clock from a source clock. A small select code picks the division ratio. The ratio does not come from a simple "code plus one" rule. It comes from one of four fixed, non-linear ratio tables, and an elaboration-time parameter picks which table is built. The tables include repeated entries, odd ratios, even sequences and a step-of-four sequence. An enable gate sits in front of the divider. While the gate is off, the divided output rests low.

The output has a duty cycle as close to half as the source permits. Even ratios are high for exactly half the period. Odd ratios use a second register on the falling source edge, which stretches the high phase by half a source cycle, so odd ratios are also high for exactly N/2 source cycles.

Changes to the select code and to the gate are sampled only at the end of an output period. As a result, the output never shows a shortened pulse.

Top module: `clkdiv_tbl_gated`

## Requirements
- R1: With TABLE_ID = 0, select values 0..7 (the plain binary value of `ratio_sel`) give ratios 2, 2, 3, 4, 5, 6, 7, 8.
- R2: With TABLE_ID = 1, select value k gives ratio 2*(k+1), which is 2 through 16.
- R3: With TABLE_ID = 2, select value 0 gives ratio 4, and select value k>0 gives ratio 2*(k+1).
- R4: With TABLE_ID = 3, select value k gives ratio 4*(k+1), which is 4 through 32.
- R5: For ratio N, each output period lasts N source cycles, and the output is high for exactly N/2 source cycles. For odd N this includes the half cycle added on the falling source edge.
- R6: A new select value takes effect only at the start of the next output period. The period in progress completes with its old ratio.
- R7: When `gate_en` falls, the period in progress completes with its full high phase. The output then stays low for as long as the gate is off.
- R8: When `gate_en` rises while the divider is idle, the output goes high at the first rising source edge that samples it.
- R9: `rst` is synchronous and active high. It forces the output low, and the divider stays idle afterwards while `gate_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | input | 1 | Enable gate, sampled at period boundaries |
| ratio_sel | input | SEL_W (3) | Select code mapped through the chosen ratio table |
| clk_div_o | output | 1 | Divided clock |

## Verification
The hardest case to reach is a select or gate change that lands in the middle of an output period, especially inside the high phase of a long odd or step-of-four ratio. That is the only situation in which a runt pulse could appear. The bench runs all four table variants side by side. It changes the select code at pseudo-random cycle offsets and measures every completed period in half-cycle resolution, requiring equal high and low phases. It also aligns one deliberate change and one gate drop to a measured rising edge of the output, so it can confirm that the interrupted period finishes at its old length.

// File: rtl/clkdiv_tbl_pkg.sv
package clkdiv_tbl_pkg;

  // Ratio for a select code under one of the four table variants.
  // 0: floor-at-two linear, 1: even from two, 2: even with floor four, 3: step of four.
  function automatic int ratio_of(input int tid, input int sel);
    case (tid)
      0:       return (sel < 2) ? 2 : sel + 1;
      1:       return 2 * (sel + 1);
      2:       return (sel == 0) ? 4 : 2 * (sel + 1);
      default: return 4 * (sel + 1);
    endcase
  endfunction

  function automatic int max_ratio(input int tid, input int nsel);
    int m;
    m = 0;
    for (int s = 0; s < nsel; s++)
      if (ratio_of(tid, s) > m) m = ratio_of(tid, s);
    return m;
  endfunction

  function automatic bit is_legal(input int tid, input int nsel, input int r);
    bit hit;
    hit = 1'b0;
    for (int s = 0; s < nsel; s++)
      if (ratio_of(tid, s) == r) hit = 1'b1;
    return hit;
  endfunction

endpackage

// File: rtl/clkdiv_ratio_map.sv
module clkdiv_ratio_map #(
  parameter int TABLE_ID = 0,
  parameter int SEL_W    = 3,
  parameter int RATIO_W  = 6
) (
  input  logic [SEL_W-1:0]   sel_i,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam int NUM_SEL = 1 << SEL_W;

  logic [RATIO_W-1:0] rom [NUM_SEL];

  // Constant table, elaborated from the chosen variant (small LUT ROM).
  for (genvar g = 0; g < NUM_SEL; g++) begin : gen_rom
    assign rom[g] = RATIO_W'(clkdiv_tbl_pkg::ratio_of(TABLE_ID, g));
  end

  assign ratio_o = rom[sel_i];

endmodule

// File: rtl/clkdiv_period_ctr.sv
module clkdiv_period_ctr #(
  parameter int RATIO_W = 6
) (
  input  logic               clk_src,
  input  logic               rst,
  input  logic               gate_en,
  input  logic [RATIO_W-1:0] ratio_nxt,
  output logic [RATIO_W-1:0] ratio_q,
  output logic [RATIO_W-1:0] cnt_q,
  output logic               run_q,
  output logic               hi_q
);
  logic               at_end;
  logic               run_d;
  logic               hi_d;
  logic [RATIO_W-1:0] cnt_d;
  logic [RATIO_W-1:0] ratio_d;

  // A period ends on its last count, or at once while idle.
  assign at_end = !run_q || (cnt_q == ratio_q - 1'b1);

  always_comb begin
    run_d   = run_q;
    cnt_d   = cnt_q + 1'b1;
    ratio_d = ratio_q;
    if (at_end) begin
      run_d = gate_en;
      cnt_d = '0;
      if (gate_en) ratio_d = ratio_nxt;
    end
    // First floor(N/2) cycles of each period are high.
    hi_d = run_d && (cnt_d < (ratio_d >> 1));
  end

  always_ff @(posedge clk_src) begin
    if (rst) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= '0;
      hi_q    <= 1'b0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      hi_q    <= hi_d;
    end
  end

endmodule

// File: rtl/clkdiv_halfcycle_ext.sv
module clkdiv_halfcycle_ext (
  input  logic clk_src,
  input  logic rst,
  input  logic hi_i,
  input  logic odd_i,
  output logic ext_q
);
  // Falling-edge copy of the high phase, used only for odd ratios.
  always_ff @(negedge clk_src) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= hi_i & odd_i;
  end

endmodule

// File: rtl/clkdiv_tbl_gated.sv
module clkdiv_tbl_gated #(
  parameter int TABLE_ID = 0,
  parameter int SEL_W    = 3
) (
  input  logic             clk_src,
  input  logic             rst,
  input  logic             gate_en,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             clk_div_o
);
  localparam int NUM_SEL  = 1 << SEL_W;
  localparam int MAX_RAT  = clkdiv_tbl_pkg::max_ratio(TABLE_ID, NUM_SEL);
  localparam int RATIO_W  = $clog2(MAX_RAT + 1);

  logic [RATIO_W-1:0] ratio_nxt;
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] cnt_q;
  logic               run_q;
  logic               hi_q;
  logic               ext_q;

  clkdiv_ratio_map #(
    .TABLE_ID(TABLE_ID), .SEL_W(SEL_W), .RATIO_W(RATIO_W)
  ) u_map (
    .sel_i  (ratio_sel),
    .ratio_o(ratio_nxt)
  );

  clkdiv_period_ctr #(.RATIO_W(RATIO_W)) u_ctr (
    .clk_src  (clk_src),
    .rst      (rst),
    .gate_en  (gate_en),
    .ratio_nxt(ratio_nxt),
    .ratio_q  (ratio_q),
    .cnt_q    (cnt_q),
    .run_q    (run_q),
    .hi_q     (hi_q)
  );

  clkdiv_halfcycle_ext u_ext (
    .clk_src(clk_src),
    .rst    (rst),
    .hi_i   (hi_q),
    .odd_i  (ratio_q[0]),
    .ext_q  (ext_q)
  );

  // Both terms are flop outputs; the falling copy only overlaps-then-extends.
  assign clk_div_o = hi_q | ext_q;

endmodule

// File: rtl/clkdiv_tbl_gated_chk.sv
module clkdiv_tbl_gated_chk #(
  parameter int TABLE_ID = 0,
  parameter int NUM_SEL  = 8,
  parameter int RATIO_W  = 6
) (
  input logic               clk_src,
  input logic               rst,
  input logic               clk_div_o,
  input logic [RATIO_W-1:0] ratio_q,
  input logic [RATIO_W-1:0] cnt_q,
  input logic               run_q
);

  // R1 R2 R3 R4: an active ratio is always an entry of the chosen table
  p_ratio_legal_r1: assert property (@(posedge clk_src) disable iff (rst)
    run_q |-> clkdiv_tbl_pkg::is_legal(TABLE_ID, NUM_SEL, int'(ratio_q)));

  p_cnt_in_range_r5: assert property (@(posedge clk_src) disable iff (rst)
    run_q |-> (cnt_q < ratio_q));

  p_ratio_hold_r6: assert property (@(posedge clk_src) disable iff (rst)
    (run_q && cnt_q != '0) |-> $stable(ratio_q));

  p_stop_at_end_r7: assert property (@(posedge clk_src) disable iff (rst)
    ($past(run_q) && !run_q) |-> (int'($past(cnt_q)) == int'($past(ratio_q)) - 1));

  p_idle_low_r7: assert property (@(posedge clk_src) disable iff (rst)
    (!run_q && $past(!run_q)) |-> !clk_div_o);

endmodule

bind clkdiv_tbl_gated clkdiv_tbl_gated_chk #(
  .TABLE_ID(TABLE_ID), .NUM_SEL(NUM_SEL), .RATIO_W(RATIO_W)
) u_chk (
  .clk_src  (clk_src),
  .rst      (rst),
  .clk_div_o(clk_div_o),
  .ratio_q  (ratio_q),
  .cnt_q    (cnt_q),
  .run_q    (run_q)
);

// File: tb/clkdiv_tbl_gated_bench.sv
`timescale 1ns/100ps

module clkdiv_tbl_gated_meter (
  input  logic clk,
  input  int   epoch,
  input  logic sig,
  output int   last_hi,
  output int   last_per,
  output int   per_cnt,
  output int   bad
);
  int hi_run, lo_run, hi_prev, seen;
  bit prev, started;

  initial begin
    last_hi = 0; last_per = 0; per_cnt = 0; bad = 0;
    hi_run = 0; lo_run = 0; hi_prev = 0; seen = 0;
    prev = 0; started = 0;
  end

  // Half-cycle resolution: sample 1.25 ns after every source edge.
  always begin
    @(clk);
    #1.25;
    if (epoch != seen) begin
      seen = epoch; started = 0; bad = 0;
    end
    if (sig) begin
      if (!prev) begin
        if (started) begin
          last_per = hi_prev + lo_run;
          if (hi_prev != lo_run) bad++;
          per_cnt++;
        end
        started = 1;
        hi_run = 1;
      end else hi_run++;
    end else begin
      if (prev) begin
        last_hi = hi_run; hi_prev = hi_run; lo_run = 1;
      end else lo_run++;
    end
    prev = sig;
  end
endmodule

module clkdiv_tbl_gated_bench;
  logic       clk_src = 1'b0;
  logic       rst     = 1'b1;
  logic       gate_en = 1'b0;
  logic [2:0] ratio_sel = 3'd0;
  logic [3:0] outs;
  int         epoch = 0;
  int         m_hi [4];
  int         m_per[4];
  int         m_cnt[4];
  int         m_bad[4];
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk_src = ~clk_src;

  for (genvar t = 0; t < 4; t++) begin : gen_tbl
    clkdiv_tbl_gated #(.TABLE_ID(t)) u_clkdiv_tbl_gated (
      .clk_src  (clk_src),
      .rst      (rst),
      .gate_en  (gate_en),
      .ratio_sel(ratio_sel),
      .clk_div_o(outs[t])
    );
    clkdiv_tbl_gated_meter u_meter (
      .clk(clk_src), .epoch(epoch), .sig(outs[t]),
      .last_hi(m_hi[t]), .last_per(m_per[t]), .per_cnt(m_cnt[t]), .bad(m_bad[t])
    );
  end

  // Expected ratio, from the requirement text.
  function automatic int exp_ratio(input int t, input int s);
    int lin0 [8] = '{2, 2, 3, 4, 5, 6, 7, 8};
    case (t)
      0:       return lin0[s];
      1:       return 2 * s + 2;
      2:       return (s == 0) ? 4 : 2 * s + 2;
      default: return 4 * s + 4;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_src);
      #1.25;
    end
  endtask

  function automatic string tag_of(input int t);
    case (t)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin : watchdog
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int snap;
    int lows;
    // R9: output low in reset and afterwards while gated off
    cyc(4);
    chk("R9 low during reset", int'(outs), 0);
    rst = 1'b0;
    cyc(6);
    chk("R9 idle after reset", int'(outs), 0);

    // R8: start from idle on the first sampling edge
    gate_en = 1'b1;
    cyc(1);
    chk("R8 start edge", int'(outs), 4'hF);

    // R1 R2 R3 R4 R5: full sweep of select codes for all four tables
    for (int s = 0; s < 8; s++) begin
      ratio_sel = 3'(s);
      epoch++;
      cyc(110);
      for (int t = 0; t < 4; t++) begin
        chk($sformatf("%s R5 high sel=%0d", tag_of(t), s), m_hi[t], exp_ratio(t, s));
        chk($sformatf("%s R5 period sel=%0d", tag_of(t), s), m_per[t], 2 * exp_ratio(t, s));
        chk($sformatf("R5 balance t=%0d sel=%0d", t, s), m_bad[t], 0);
      end
    end

    // R6 R5: select churn at arbitrary offsets, no runt or unbalanced period
    epoch++;
    for (int i = 0; i < 60; i++) begin
      ratio_sel = 3'($urandom_range(0, 7));
      cyc(int'($urandom_range(1, 23)));
    end
    cyc(80);
    for (int t = 0; t < 4; t++)
      chk($sformatf("R6 churn balance t=%0d", t), m_bad[t], 0);

    // R6: change inside a period of table 3, old ratio finishes first
    ratio_sel = 3'd0;
    cyc(80);
    snap = m_cnt[3];
    wait (m_cnt[3] != snap);
    cyc(1);
    ratio_sel = 3'd7;
    snap = m_cnt[3];
    wait (m_cnt[3] != snap);
    chk("R6 old ratio kept", m_per[3], 8);
    snap = m_cnt[3];
    wait (m_cnt[3] != snap);
    chk("R6 new ratio next", m_per[3], 64);

    // R7: gate dropped inside a high phase
    ratio_sel = 3'd5;
    cyc(120);
    snap = m_cnt[3];
    wait (m_cnt[3] != snap);
    cyc(2);
    gate_en = 1'b0;
    cyc(70);
    for (int t = 0; t < 4; t++)
      chk($sformatf("R7 last high full t=%0d", t), m_hi[t], exp_ratio(t, 5));
    lows = 0;
    for (int i = 0; i < 80; i++) begin
      @(clk_src);
      #1.25;
      if (outs != 4'h0) lows++;
    end
    chk("R7 held low while gated", lows, 0);

    // R9: reset while running
    gate_en = 1'b1;
    cyc(30);
    rst = 1'b1;
    gate_en = 1'b0;
    cyc(2);
    @(negedge clk_src);
    #1.25;
    chk("R9 reset forces low", int'(outs), 0);
    cyc(1);
    rst = 1'b0;
    cyc(10);
    chk("R9 idle after mid-run reset", int'(outs), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule